// File: doc/BRIEF.md
# Lowest-Set-Bit Manipulation Unit

This execution unit performs three bit manipulations centred on the lowest set bit of an operand. It can clear that bit, build a mask that runs from bit 0 up to and including that bit, or keep that bit alone. It also produces the arithmetic status flags for the operation. An upstream decoder supplies the source operand, the operand-size choice, the 3-bit operation selector taken from the instruction's register field, and three gating inputs: vector-extension prefix present, vector-length bit, and feature enable. The unit works out whether the instruction is legal. For a legal instruction it returns the result and a write-enable for the destination register. For an illegal one it raises an undefined-opcode indication.

The datapath is one combinational level. Parameter `OUT_REG` decides whether one output register stage follows it. Operands are either the full width or the low half, and the result is zero-extended in the half-width case. No result or flag update is produced unless `issue` is high.

Top module: `lsb_unit`

## Requirements
- R1: Selector value 1 clears the lowest set bit: result = s AND (s - 1), where s is the sized source.
- R2: Selector value 2 builds a mask up to the lowest set bit: result = s XOR (s - 1). A zero source gives all ones at the selected size.
- R3: Selector value 3 isolates the lowest set bit: result = s AND (-s).
- R4: Selector values 0, 4, 5, 6 and 7 raise `ill_op`, and they keep `res_we` and `flags_we` low.
- R5: `ill_op` is also raised, with both enables low, when `feat_en` is 0, when `vex_on` is 0, or when `vex_l` is 1.
- R6: `wide`=1 selects full DATA_W operation. `wide`=0 uses only the low DATA_W/2 source bits and writes zeros to the upper half of `res`.
- R7: On a legal operation `zf` is 1 exactly when the result at the selected size is all zeros.
- R8: On a legal operation `sf` equals the top bit of the result at the selected size (bit DATA_W-1, or bit DATA_W/2-1).
- R9: `cf` is 1 when the sized source is zero for selectors 1 and 2. For selector 3, `cf` is 1 when the sized source is nonzero.
- R10: `of`, `pf` and `af` are always 0.
- R11: With OUT_REG=1, the outputs reflect the inputs of the previous clock edge. Synchronous reset clears all outputs. A cycle with `issue`=0, or an illegal cycle, drives `res` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is presented this cycle |
| src | input | DATA_W | Source operand |
| wide | input | 1 | 1 = full-width operand, 0 = half-width |
| reg_fld | input | 3 | Operation selector from the register field |
| vex_on | input | 1 | Vector-extension prefix present |
| vex_l | input | 1 | Vector-length bit (must be 0) |
| feat_en | input | 1 | Bit-manipulation feature enabled |
| res | output | DATA_W | Result for the destination register |
| res_we | output | 1 | Destination write enable |
| flags_we | output | 1 | Flag update enable |
| ill_op | output | 1 | Undefined-opcode indication |
| cf | output | 1 | Carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag (always 0) |
| pf | output | 1 | Parity flag (always 0) |
| af | output | 1 | Auxiliary-carry flag (always 0) |

## Verification
The bench builds the unit with DATA_W=64 and OUT_REG=1. This makes both operand sizes reachable, so a source whose low half is zero and whose upper half is nonzero counts as zero in half-width mode but not in full-width mode. The registered build also brings the one-cycle latency and the clear-on-reset behaviour into the checks. It covers back-to-back issues and idle cycles in between, and it lets the in-RTL assertions compare each output against inputs taken a cycle earlier.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [1:0] {
    LSB_NONE = 2'd0,
    LSB_CLR  = 2'd1,
    LSB_MSK  = 2'd2,
    LSB_ISO  = 2'd3
  } lsb_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
    logic af;
  } lsb_flags_t;
endpackage

// File: rtl/lsb_decode.sv
module lsb_decode
  import lsb_pkg::*;
(
  input  logic       issue,
  input  logic [2:0] reg_fld,
  input  logic       vex_on,
  input  logic       vex_l,
  input  logic       feat_en,
  output lsb_op_e    op,
  output logic       legal,
  output logic       ill
);
  logic gate_ok;

  always_comb begin
    case (reg_fld)
      3'd1:    op = LSB_CLR;
      3'd2:    op = LSB_MSK;
      3'd3:    op = LSB_ISO;
      default: op = LSB_NONE;
    endcase
    gate_ok = feat_en && vex_on && !vex_l;
    legal   = issue && gate_ok && (op != LSB_NONE);
    ill     = issue && !legal;
  end
endmodule

// File: rtl/lsb_alu.sv
module lsb_alu
  import lsb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  input  logic              wide,
  input  lsb_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              src_zero
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] s;
  logic [DATA_W-1:0] dec;
  logic [DATA_W-1:0] neg;
  logic [DATA_W-1:0] raw;

  always_comb begin
    size_mask = wide ? {DATA_W{1'b1}} : LO_MASK;
    s         = src & size_mask;
    dec       = s - DATA_W'(1);
    neg       = ~s + DATA_W'(1);
    src_zero  = (s == '0);
    case (op)
      LSB_CLR: raw = s & dec;
      LSB_MSK: raw = s ^ dec;
      LSB_ISO: raw = s & neg;
      default: raw = '0;
    endcase
    res = raw & size_mask;
  end
endmodule

// File: rtl/lsb_flags.sv
module lsb_flags
  import lsb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res,
  input  logic              wide,
  input  lsb_op_e           op,
  input  logic              src_zero,
  output lsb_flags_t        flags
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    flags    = '0;
    flags.zf = (res == '0);
    flags.sf = wide ? res[DATA_W-1] : res[HALF_W-1];
    flags.cf = (op == LSB_ISO) ? !src_zero : src_zero;
  end
endmodule

// File: rtl/lsb_unit.sv
module lsb_unit
  import lsb_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] src,
  input  logic              wide,
  input  logic [2:0]        reg_fld,
  input  logic              vex_on,
  input  logic              vex_l,
  input  logic              feat_en,
  output logic [DATA_W-1:0] res,
  output logic              res_we,
  output logic              flags_we,
  output logic              ill_op,
  output logic              cf,
  output logic              zf,
  output logic              sf,
  output logic              of,
  output logic              pf,
  output logic              af
);
  localparam int HALF_W = DATA_W / 2;

  lsb_op_e           op;
  logic              legal;
  logic              ill;
  logic [DATA_W-1:0] alu_res;
  logic              src_zero;
  lsb_flags_t        alu_flags;

  lsb_decode u_dec (
    .issue   (issue),
    .reg_fld (reg_fld),
    .vex_on  (vex_on),
    .vex_l   (vex_l),
    .feat_en (feat_en),
    .op      (op),
    .legal   (legal),
    .ill     (ill)
  );

  lsb_alu #(.DATA_W(DATA_W)) u_alu (
    .src      (src),
    .wide     (wide),
    .op       (op),
    .res      (alu_res),
    .src_zero (src_zero)
  );

  lsb_flags #(.DATA_W(DATA_W)) u_flg (
    .res      (alu_res),
    .wide     (wide),
    .op       (op),
    .src_zero (src_zero),
    .flags    (alu_flags)
  );

  logic [DATA_W-1:0] nxt_res;
  lsb_flags_t        nxt_flags;
  lsb_flags_t        out_flags;

  always_comb begin
    nxt_res   = legal ? alu_res : '0;
    nxt_flags = legal ? alu_flags : '0;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res       <= '0;
          res_we    <= 1'b0;
          flags_we  <= 1'b0;
          ill_op    <= 1'b0;
          out_flags <= '0;
        end else begin
          res       <= nxt_res;
          res_we    <= legal;
          flags_we  <= legal;
          ill_op    <= ill;
          out_flags <= nxt_flags;
        end
      end

      // R4 R5: gating failures must show up as an illegal opcode
      a_r5_gate_illegal: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && issue && (!vex_on || vex_l || !feat_en)) |-> ill_op && !res_we);
      a_r4_bad_selector: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && issue && (reg_fld == 3'd0 || reg_fld > 3'd3)) |-> ill_op && !flags_we);
      // R6: upper half cleared for half-width results
      a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !wide) |-> res[DATA_W-1:HALF_W] == '0);
      // R11: no write without an issue on the previous edge
      a_r11_no_spurious_we: assert property (@(posedge clk) disable iff (rst)
        res_we |-> $past(issue));
    end else begin : g_comb
      always_comb begin
        res       = nxt_res;
        res_we    = legal;
        flags_we  = legal;
        ill_op    = ill;
        out_flags = nxt_flags;
      end
    end
  endgenerate

  assign cf = out_flags.cf;
  assign zf = out_flags.zf;
  assign sf = out_flags.sf;
  assign of = out_flags.of;
  assign pf = out_flags.pf;
  assign af = out_flags.af;

  // R4: illegal excludes any update
  a_r4_ill_blocks_we: assert property (@(posedge clk) disable iff (rst)
    ill_op |-> !res_we && !flags_we);
  // R7: zero flag agrees with the written result
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> zf == (res == '0));
  // R10: undefined and overflow flags stay low
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> !(of || pf || af));
endmodule

// File: tb/test_lsb_unit.sv
`timescale 1ns/1ps
module test_lsb_unit;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              issue;
  logic [DATA_W-1:0] src;
  logic              wide;
  logic [2:0]        reg_fld;
  logic              vex_on;
  logic              vex_l;
  logic              feat_en;
  logic [DATA_W-1:0] res;
  logic              res_we, flags_we, ill_op, cf, zf, sf, of, pf, af;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [72:0] vec;
    string       req;
  } item_t;

  item_t sbq[$];

  always #2 clk = ~clk;

  lsb_unit #(.DATA_W(DATA_W), .OUT_REG(1'b1)) i_lsb_unit (
    .clk(clk), .rst(rst), .issue(issue), .src(src), .wide(wide),
    .reg_fld(reg_fld), .vex_on(vex_on), .vex_l(vex_l), .feat_en(feat_en),
    .res(res), .res_we(res_we), .flags_we(flags_we), .ill_op(ill_op),
    .cf(cf), .zf(zf), .sf(sf), .of(of), .pf(pf), .af(af)
  );

  function automatic logic [72:0] model(logic [63:0] s_in, logic w, logic [2:0] rf,
                                        logic vx, logic l, logic fe, logic is);
    logic [63:0] s, r;
    int n, k;
    logic lg, c, z, sg;
    if (!is) return '0;
    lg = fe && vx && !l && (rf >= 3'd1) && (rf <= 3'd3);
    if (!lg) return {64'd0, 1'b0, 1'b0, 1'b1, 6'd0};
    n = w ? 64 : 32;
    s = w ? s_in : {32'd0, s_in[31:0]};
    k = -1;
    for (int i = 0; i < n; i++) if (s[i] && k < 0) k = i;
    r = '0;
    case (rf)
      3'd1: begin r = s; if (k >= 0) r[k] = 1'b0; end
      3'd2: begin
        if (k < 0) begin for (int i = 0; i < n; i++) r[i] = 1'b1; end
        else begin for (int i = 0; i <= k; i++) r[i] = 1'b1; end
      end
      default: if (k >= 0) r[k] = 1'b1;
    endcase
    z  = (r == '0);
    sg = r[n-1];
    c  = (rf == 3'd3) ? (k >= 0) : (k < 0);
    return {r, 1'b1, 1'b1, 1'b0, c, z, sg, 3'b000};
  endfunction

  task automatic drive(input logic is, input logic [63:0] s, input logic w,
                       input logic [2:0] rf, input logic vx, input logic l,
                       input logic fe, input string req);
    item_t it;
    @(negedge clk);
    issue = is; src = s; wide = w; reg_fld = rf; vex_on = vx; vex_l = l; feat_en = fe;
    it.vec = model(s, w, rf, vx, l, fe, is);
    it.req = req;
    sbq.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [72:0] act;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sbq.size() > 0) begin
        it  = sbq.pop_front();
        act = {res, res_we, flags_we, ill_op, cf, zf, sf, of, pf, af};
        total++;
        if (act !== it.vec) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.vec);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; issue = 1'b0; src = '0; wide = 1'b1; reg_fld = 3'd0;
    vex_on = 1'b0; vex_l = 1'b0; feat_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if ({res, res_we, flags_we, ill_op, cf, zf, sf, of, pf, af} !== '0) begin
      bad++;
      $display("FAIL R11 reset actual=%h expected=0",
               {res, res_we, flags_we, ill_op, cf, zf, sf, of, pf, af});
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 clear lowest set bit, full width
    drive(1, 64'h00F0_0000_0000_0000, 1, 3'd1, 1, 0, 1, "R1 clr wide");
    drive(1, 64'h8000_0000_0000_0000, 1, 3'd1, 1, 0, 1, "R1 R7 clr to zero");
    drive(1, 64'h0, 1, 3'd1, 1, 0, 1, "R9 clr zero src");
    // R2 mask
    drive(1, 64'h0000_0000_0000_0B00, 1, 3'd2, 1, 0, 1, "R2 msk");
    drive(1, 64'h8000_0000_0000_0000, 1, 3'd2, 1, 0, 1, "R2 R8 msk top bit");
    drive(1, 64'h0, 1, 3'd2, 1, 0, 1, "R2 R9 msk zero src");
    // R3 isolate
    drive(1, 64'hC000_0000_0000_0000, 1, 3'd3, 1, 0, 1, "R3 R8 iso top");
    drive(1, 64'h0000_1234_5678_9AB0, 1, 3'd3, 1, 0, 1, "R3 iso");
    drive(1, 64'h0, 1, 3'd3, 1, 0, 1, "R3 R9 iso zero src");
    // idle cycle
    drive(0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd1, 1, 0, 1, "R11 idle");
    // R6 half width
    drive(1, 64'hFFFF_FFFF_0000_0010, 0, 3'd1, 1, 0, 1, "R6 clr narrow");
    drive(1, 64'hFFFF_FFFF_0000_0000, 0, 3'd1, 1, 0, 1, "R6 R9 clr narrow zero");
    drive(1, 64'hFFFF_FFFF_0000_0000, 0, 3'd2, 1, 0, 1, "R6 R8 msk narrow zero");
    drive(1, 64'hFFFF_FFFF_0000_0000, 0, 3'd3, 1, 0, 1, "R6 R9 iso narrow zero");
    drive(1, 64'h1234_5678_8000_0000, 0, 3'd3, 1, 0, 1, "R6 R8 iso narrow sign");
    drive(1, 64'h0000_0001_0000_0000, 1, 3'd3, 1, 0, 1, "R6 iso wide upper");
    // R4 bad selectors
    drive(1, 64'h10, 1, 3'd0, 1, 0, 1, "R4 sel0");
    drive(1, 64'h10, 1, 3'd4, 1, 0, 1, "R4 sel4");
    drive(1, 64'h10, 1, 3'd7, 1, 0, 1, "R4 sel7");
    // R5 gating
    drive(1, 64'h10, 1, 3'd1, 0, 0, 1, "R5 no prefix");
    drive(1, 64'h10, 1, 3'd2, 1, 1, 1, "R5 length bit");
    drive(1, 64'h10, 1, 3'd3, 1, 0, 0, "R5 feature off");
    // R10 back-to-back legal after illegal
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd2, 1, 0, 1, "R10 msk all ones");
    drive(1, 64'h0000_0000_0000_0001, 0, 3'd1, 1, 0, 1, "R10 clr one");
    drive(0, 64'h0, 1, 3'd0, 0, 0, 0, "R11 idle tail");
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule